// File: doc/BRIEF.md
# Register-Mapped Synchronous Serial Master

This block is a memory-mapped serial master for SPI-style links. Software programs the frame shape (length of 4 to 16 bits, idle clock level, sampling edge and bit order) and a fractional clock divider through a small register bus. It then issues pulse commands to turn on the master, the transmitter and the receiver. A frame written to the transmit register waits in a one-entry holding buffer. It moves into the shift engine as soon as the engine is free and transmission is allowed. The frame sampled from the input line lands in a one-entry receive buffer.

Two level flags drive one interrupt line through an enable mask. One flag means the holding buffer can take another frame. The other means a received frame is waiting. With the holding buffer and the shift register together, software can keep two frames in flight ahead of the received data. Chip selects are not part of the block and are driven elsewhere.

The register map uses byte offsets on the bus: control 0x00, frame 0x04, command 0x08, status 0x0C, divider 0x10, receive data 0x14, transmit data 0x18, flags 0x1C, interrupt enable 0x20. Read data appears on the cycle after the read strobe.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, status (0x0C) reads 0x40 and flags (0x1C) read 0x2. The interrupt line and the serial clock are low, and receive, transmit and master are all off.
- R2: A frame starts shifting only when all four of these hold: control bit 0 (synchronous mode) is 1, master is on, transmit is on, and the holding buffer is full. While any of them is missing, the frame stays buffered and status bit 6 reads 0.
- R3: Frame register (0x04) bits 3:0 hold the frame length minus 3. Results outside 4..16 are clamped to the nearest limit: field 0 gives 4 bits, field 13 gives 16 bits and field 15 gives 16 bits.
- R4: The command register (0x08) acts on written ones only. Bit 0 turns receive on, bit 1 turns it off, bit 2 turns transmit on, bit 3 turns it off, and bit 4 turns master on. A zero bit changes nothing. Status bit 1 follows the transmit enable.
- R5: Status bit 6 is 1 while the holding buffer is empty. Status bit 7 is 1 while a received frame is waiting. Status bit 5 is set when a frame finishes with the holding buffer empty.
- R6: With divider value DIV (0x10, bits 21:0), the serial clock half period averages (256+DIV)/256 input clocks. The 16 clock edges of an 8-bit frame span 15, 22 and 30 cycles for DIV values 0, 128 and 256.
- R7: Control bit 8 sets the resting clock level, which the clock line holds between frames. Control bit 9 sets the sampling edge. When bit 9 is 0, data is sampled on the leading edge and changed on the trailing edge. When bit 9 is 1, data is changed on the leading edge and sampled on the trailing edge.
- R8: Control bit 10 set shifts the most significant bit first; clear shifts the least significant bit first. Received bits are assembled in the same order.
- R9: Reading receive data (0x14) returns the received frame's low 9 bits in bits 8:0, with bits 14 and 15 (error flags) reading 0. The read clears status bit 7.
- R10: A frame that completes while a received frame is still waiting replaces it, and status bit 7 stays 1.
- R11: With receive off, completed frames are not stored and status bit 7 does not rise.
- R12: Flag bit 1 mirrors buffer-empty and flag bit 2 mirrors received-valid. Interrupt enable (0x20) uses the same bit positions. The interrupt output goes high one cycle after any enabled flag is set.
- R13: The holding buffer accepts a frame while another is shifting. A transmit write (0x18) while the buffer is full is dropped.
- R14: An accepted write to transmit data clears status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt, high while an enabled flag is set |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The divider assertion assumes the divider value does not change while a frame is shifting. The bench only rewrites it when the block is idle and the complete bit has been seen. The idle-clock assertion expects the polarity bit to change only between frames, and every configuration write in the bench follows a completed or unstarted transfer. The serial input is looped back from the data output, so every received value is determined by the transmitted frame and the programmed length.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_FRAME = 8'h04;
  localparam logic [7:0] OFS_CMD   = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [7:0] OFS_DIV   = 8'h10;
  localparam logic [7:0] OFS_RXD   = 8'h14;
  localparam logic [7:0] OFS_TXD   = 8'h18;
  localparam logic [7:0] OFS_FLAG  = 8'h1C;
  localparam logic [7:0] OFS_IEN   = 8'h20;

  localparam int CB_SYNC = 0;
  localparam int CB_CPOL = 8;
  localparam int CB_CPHA = 9;
  localparam int CB_MSBF = 10;

  localparam int KB_RXON  = 0;
  localparam int KB_RXOFF = 1;
  localparam int KB_TXON  = 2;
  localparam int KB_TXOFF = 3;
  localparam int KB_MSTON = 4;

  localparam int SB_TXON  = 1;
  localparam int SB_DONE  = 5;
  localparam int SB_FREE  = 6;
  localparam int SB_RXVAL = 7;

  localparam int IB_FREE  = 1;
  localparam int IB_RXVAL = 2;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       msbf;
    logic [4:0] nbits;
  } frame_cfg_t;
endpackage

// File: rtl/ssm_fracdiv.sv
module ssm_fracdiv #(
  parameter int DIV_W  = 22,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int ACC_W = DIV_W + 2;
  localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] period;
  logic [ACC_W-1:0] nxt;

  assign period = ACC_W'(div) + UNIT;
  assign nxt    = acc + UNIT;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (nxt >= period) begin
      acc  <= nxt - period;
      tick <= 1'b1;
    end else begin
      acc  <= nxt;
      tick <= 1'b0;
    end
  end

  // R6: remainder never reaches a whole half period while the divider is steady
  assert_acc_range_R6: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $stable(div)) |-> (acc < period));
endmodule

// File: rtl/ssm_shift.sv
module ssm_shift
  import ssm_pkg::*;
#(
  parameter int MAXB = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [MAXB-1:0] tx_in,
  input  frame_cfg_t      cfg,
  input  logic            idle_pol,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [MAXB-1:0] rx_word,
  output logic            sclk,
  output logic            mosi
);
  localparam int IW = $clog2(MAXB);
  localparam int BW = $clog2(MAXB + 1);
  localparam int KW = BW + 1;

  frame_cfg_t      cfg_q;
  logic [MAXB-1:0] txw;
  logic [KW-1:0]   k;
  logic [BW-1:0]   b;
  logic [KW-1:0]   last_k;
  logic [IW-1:0]   first_pos;

  assign last_k    = {cfg_q.nbits[BW-1:0], 1'b0} - KW'(1);
  assign first_pos = cfg.msbf ? IW'(cfg.nbits - 5'd1) : '0;

  function automatic logic [IW-1:0] pos(input logic [BW-1:0] bi);
    logic [BW-1:0] t;
    t = cfg_q.msbf ? (cfg_q.nbits[BW-1:0] - BW'(1) - bi) : bi;
    return t[IW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      k       <= '0;
      b       <= '0;
      cfg_q   <= '0;
      txw     <= '0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= idle_pol;
        if (start) begin
          busy    <= 1'b1;
          cfg_q   <= cfg;
          txw     <= tx_in;
          k       <= '0;
          b       <= '0;
          rx_word <= '0;
          if (!cfg.cpha) mosi <= tx_in[first_pos];
        end
      end else if (tick) begin
        sclk <= ~sclk;
        k    <= k + KW'(1);
        if (!cfg_q.cpha) begin
          if (!k[0]) begin
            rx_word[pos(b)] <= miso;
          end else begin
            b <= b + BW'(1);
            if ((b + BW'(1)) < cfg_q.nbits[BW-1:0]) mosi <= txw[pos(b + BW'(1))];
          end
        end else begin
          if (!k[0]) begin
            mosi <= txw[pos(b)];
          end else begin
            rx_word[pos(b)] <= miso;
            b <= b + BW'(1);
          end
        end
        if (k == last_k) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R7: between frames the clock line follows the resting level
  assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sclk == $past(idle_pol)));
  // R2: a completion pulse only follows a frame in progress
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DIV_W = 22,
  parameter int FRACW = 8,
  parameter int FW    = 4,
  parameter int MINB  = 4,
  parameter int MAXB  = 16,
  parameter int RXW   = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  localparam int LW = 5;

  logic ctl_sync, ctl_cpol, ctl_cpha, ctl_msbf;
  logic [FW-1:0]    frame_f;
  logic [DIV_W-1:0] div_q;
  logic rx_on, tx_on, mst_on;
  logic [MAXB-1:0] txbuf;
  logic            txbuf_v;
  logic [RXW-1:0]  rxbuf;
  logic            rx_v;
  logic            txc;
  logic [2:1]      ien;

  logic wr_en, rd_en, wr_tx, tx_take, rd_rx, start;
  logic busy, done, tick;
  logic [MAXB-1:0] rx_word;
  logic [LW-1:0] len_raw, nb;
  logic [2:1] flags;
  logic [DW-1:0] rd_mux;
  frame_cfg_t cfg;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & bus_rd;
  assign wr_tx   = wr_en && (bus_addr == AW'(OFS_TXD));
  assign tx_take = wr_tx && !txbuf_v;
  assign rd_rx   = rd_en && (bus_addr == AW'(OFS_RXD));
  assign start   = !busy && txbuf_v && tx_on && mst_on && ctl_sync;

  assign len_raw = LW'(frame_f) + LW'(3);
  always_comb begin
    if (len_raw < LW'(MINB))      nb = LW'(MINB);
    else if (len_raw > LW'(MAXB)) nb = LW'(MAXB);
    else                          nb = len_raw;
  end

  assign cfg   = '{cpol: ctl_cpol, cpha: ctl_cpha, msbf: ctl_msbf, nbits: nb};
  assign flags = {rx_v, !txbuf_v};

  always_ff @(posedge clk) begin
    if (rst) begin
      {ctl_sync, ctl_cpol, ctl_cpha, ctl_msbf} <= '0;
      frame_f <= '0;
      div_q   <= '0;
      {rx_on, tx_on, mst_on} <= '0;
      txbuf   <= '0;
      txbuf_v <= 1'b0;
      rxbuf   <= '0;
      rx_v    <= 1'b0;
      txc     <= 1'b0;
      ien     <= '0;
    end else begin
      if (wr_en) begin
        case (bus_addr)
          AW'(OFS_CTRL): begin
            ctl_sync <= bus_wdata[CB_SYNC];
            ctl_cpol <= bus_wdata[CB_CPOL];
            ctl_cpha <= bus_wdata[CB_CPHA];
            ctl_msbf <= bus_wdata[CB_MSBF];
          end
          AW'(OFS_FRAME): frame_f <= bus_wdata[FW-1:0];
          AW'(OFS_DIV):   div_q   <= bus_wdata[DIV_W-1:0];
          AW'(OFS_IEN):   ien     <= bus_wdata[2:1];
          AW'(OFS_CMD): begin
            if (bus_wdata[KB_RXON])  rx_on  <= 1'b1;
            if (bus_wdata[KB_RXOFF]) rx_on  <= 1'b0;
            if (bus_wdata[KB_TXON])  tx_on  <= 1'b1;
            if (bus_wdata[KB_TXOFF]) tx_on  <= 1'b0;
            if (bus_wdata[KB_MSTON]) mst_on <= 1'b1;
          end
          default: ;
        endcase
      end
      if (start) txbuf_v <= 1'b0;
      if (tx_take) begin
        txbuf   <= bus_wdata[MAXB-1:0];
        txbuf_v <= 1'b1;
      end
      if (tx_take)               txc <= 1'b0;
      else if (done && !txbuf_v) txc <= 1'b1;
      if (done && rx_on) begin
        rxbuf <= rx_word[RXW-1:0];
        rx_v  <= 1'b1;
      end else if (rd_rx) begin
        rx_v <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      AW'(OFS_CTRL): begin
        rd_mux[CB_SYNC] = ctl_sync;
        rd_mux[CB_CPOL] = ctl_cpol;
        rd_mux[CB_CPHA] = ctl_cpha;
        rd_mux[CB_MSBF] = ctl_msbf;
      end
      AW'(OFS_FRAME): rd_mux[FW-1:0]    = frame_f;
      AW'(OFS_DIV):   rd_mux[DIV_W-1:0] = div_q;
      AW'(OFS_STAT): begin
        rd_mux[SB_TXON]  = tx_on;
        rd_mux[SB_DONE]  = txc;
        rd_mux[SB_FREE]  = !txbuf_v;
        rd_mux[SB_RXVAL] = rx_v;
      end
      AW'(OFS_RXD):  rd_mux[RXW-1:0] = rxbuf;
      AW'(OFS_FLAG): rd_mux[2:1]     = flags;
      AW'(OFS_IEN):  rd_mux[2:1]     = ien;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_en ? rd_mux : '0;
      irq       <= |(flags & ien);
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DW-1:DIV_W], rx_word[MAXB-1:RXW]};

  ssm_fracdiv #(.DIV_W(DIV_W), .FRAC_W(FRACW)) u_div (
    .clk(clk), .rst(rst), .run(busy), .div(div_q), .tick(tick));

  ssm_shift #(.MAXB(MAXB)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_in(txbuf), .cfg(cfg),
    .idle_pol(ctl_cpol), .tick(tick), .miso(miso), .busy(busy),
    .done(done), .rx_word(rx_word), .sclk(sclk), .mosi(mosi));

  // R9: a read of receive data with no frame landing clears the valid bit
  assert_pop_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && !(done && rx_on)) |=> !rx_v);
  // R13: a write into a full holding buffer leaves its contents alone
  assert_full_write_dropped_R13: assert property (@(posedge clk) disable iff (rst)
    (wr_tx && txbuf_v) |=> $stable(txbuf));
  // R12: with every source masked the interrupt stays low
  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (rst)
    (ien == 2'b00) |=> !irq);
  // R11: with receive off a finished frame does not raise the valid bit
  assert_rx_off_R11: assert property (@(posedge clk) disable iff (rst)
    (done && !rx_on && !rx_v) |=> !rx_v);
endmodule

// File: tb/sim_sync_serial_master.sv
module sim_sync_serial_master;
  localparam logic [7:0] A_CTRL = 8'h00, A_FRAME = 8'h04, A_CMD = 8'h08, A_STAT = 8'h0C,
                         A_DIV = 8'h10, A_RXD = 8'h14, A_TXD = 8'h18, A_FLAG = 8'h1C, A_IEN = 8'h20;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, sclk, mosi;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  typedef struct { logic [15:0] d; int n; logic cpol, cpha, msbf; } item_t;
  item_t sb[$];
  logic cur_cpol = 0, cur_cpha = 0, cur_msbf = 1;
  int cur_n = 8;

  always #5 clk = ~clk;

  sync_serial_master u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(mosi));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic cfg(input logic pol, input logic pha, input logic msb, input int field);
    wr(A_CTRL, 32'h1 | (32'(pol) << 8) | (32'(pha) << 9) | (32'(msb) << 10));
    wr(A_FRAME, 32'(field));
    cur_cpol = pol; cur_cpha = pha; cur_msbf = msb;
    cur_n = (field + 3 < 4) ? 4 : (field + 3 > 16) ? 16 : field + 3;
  endtask

  task automatic push(input logic [15:0] d);
    item_t it;
    it.d = d; it.n = cur_n; it.cpol = cur_cpol; it.cpha = cur_cpha; it.msbf = cur_msbf;
    sb.push_back(it);
  endtask

  task automatic send(input logic [15:0] d);
    push(d);
    wr(A_TXD, 32'(d));
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, s);
      if (s[5]) break;
    end
  endtask

  function automatic logic [15:0] lowmask(input int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  task automatic xfer(input logic [15:0] d, input string req);
    logic [31:0] r;
    send(d);
    wait_done();
    rd(A_RXD, r);
    check(r == 32'(d & lowmask(cur_n) & 16'h1FF), req, r, 32'(d & lowmask(cur_n) & 16'h1FF));
    check(sclk == cur_cpol, "R7 idle level", sclk, cur_cpol);
  endtask

  task automatic span(input int toggles, output int s);
    logic p;
    int t, first, cnt;
    p = sclk; t = 0; first = 0; cnt = 0; s = -1;
    while (cnt < toggles && t < 5000) begin
      @(negedge clk);
      t++;
      if (sclk != p) begin
        if (cnt == 0) first = t;
        cnt++;
        s = t - first;
      end
      p = sclk;
    end
  endtask

  // scoreboard monitor: rebuilds each frame from the serial pins
  initial begin
    logic prev;
    logic bits[16];
    int nb, tog;
    prev = 0; nb = 0; tog = 0;
    forever begin
      @(negedge clk);
      if (!rst && sclk != prev && sb.size() > 0) begin
        item_t it;
        logic [15:0] w;
        it = sb[0];
        if ((sclk != it.cpol) != it.cpha) begin
          if (nb < 16) bits[nb] = mosi;
          nb++;
        end
        tog++;
        if (tog == 2 * it.n) begin
          w = '0;
          for (int i = 0; i < it.n; i++)
            if (it.msbf) w[it.n-1-i] = bits[i]; else w[i] = bits[i];
          check(nb == it.n && w == (it.d & lowmask(it.n)),
                "R8/R3 serial frame", w, it.d & lowmask(it.n));
          void'(sb.pop_front());
          nb = 0; tog = 0;
        end
      end
      prev = sclk;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int s;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(A_STAT, r); check(r == 32'h40, "R1 status", r, 32'h40);
    rd(A_FLAG, r); check(r == 32'h2, "R1 flags", r, 32'h2);
    check(irq == 0 && sclk == 0, "R1 irq/sclk", {irq, sclk}, 0);

    cfg(0, 0, 1, 5);
    wr(A_DIV, 0);
    wr(A_CMD, 32'h10);
    wr(A_CMD, 32'h05);
    rd(A_STAT, r); check(r == 32'h42, "R4 enables", r, 32'h42);
    wr(A_CMD, 32'h0);
    rd(A_STAT, r); check(r == 32'h42, "R4 zero command", r, 32'h42);

    // R6 DIV=0, R5 status after a frame, R9 read
    send(16'hA5);
    span(16, s); check(s == 15, "R6 div0", s, 15);
    wait_done();
    rd(A_STAT, r); check(r == 32'hE2, "R5 status", r, 32'hE2);
    rd(A_RXD, r); check(r == 32'hA5, "R9 rx data", r, 32'hA5);
    rd(A_STAT, r); check(r == 32'h62, "R9 pop", r, 32'h62);

    // R12 interrupts
    wr(A_IEN, 32'h4);
    repeat (2) @(negedge clk); check(irq == 0, "R12 masked", irq, 0);
    send(16'h3C); wait_done();
    repeat (2) @(negedge clk); check(irq == 1, "R12 rx irq", irq, 1);
    rd(A_RXD, r);
    repeat (2) @(negedge clk); check(irq == 0, "R12 rx irq clear", irq, 0);
    wr(A_IEN, 32'h2);
    repeat (2) @(negedge clk); check(irq == 1, "R12 free irq", irq, 1);
    wr(A_IEN, 32'h0);

    // R7 R8 all modes and orders
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 2; o++) begin
        cfg(m[1], m[0], o[0], 5);
        xfer(16'(8'h4B ^ (m * 8'h11) ^ (o * 8'h80)), "R7/R8 rx");
      end
    // R3 lengths and clamping
    cfg(1, 0, 1, 1);  xfer(16'h0009, "R3 len4");
    cfg(0, 1, 0, 13); xfer(16'hC3A5, "R3 len16");
    cfg(0, 0, 1, 0);  xfer(16'hFFF6, "R3 clamp low");
    cfg(1, 1, 1, 15); xfer(16'h8E71, "R3 clamp high");

    // R6 fractional rates
    cfg(0, 0, 1, 5);
    wr(A_DIV, 128);
    send(16'h11); span(16, s); check(s == 22, "R6 div128", s, 22);
    wait_done(); rd(A_RXD, r);
    wr(A_DIV, 256);
    send(16'h12); span(16, s); check(s == 30, "R6 div256", s, 30);
    wait_done(); rd(A_RXD, r);

    // R13 buffering, R10 overwrite
    send(16'h21);
    repeat (4) @(negedge clk);
    rd(A_STAT, r); check(r[6] == 1, "R13 buffer free while shifting", r, 32'h62);
    send(16'h42);
    rd(A_STAT, r); check(r[6] == 0, "R13 buffer full", r[6], 0);
    wr(A_TXD, 32'h99);
    wait_done();
    rd(A_STAT, r); check(r[7] == 1, "R10 valid kept", r[7], 1);
    rd(A_RXD, r); check(r == 32'h42, "R10/R13 newest frame", r, 32'h42);

    // R11 receive off
    wr(A_CMD, 32'h2);
    send(16'h55); wait_done();
    rd(A_STAT, r); check(r[7] == 0, "R11 not stored", r[7], 0);
    wr(A_CMD, 32'h1);

    // R2 transmit off, R14 done cleared by write
    wr(A_CMD, 32'h8);
    rd(A_STAT, r); check(r[1] == 0, "R4 tx off", r[1], 0);
    wr(A_TXD, 32'h66);
    repeat (40) @(negedge clk);
    rd(A_STAT, r); check(r[6] == 0, "R2 held while tx off", r[6], 0);
    check(r[5] == 0, "R14 done cleared", r[5], 0);
    push(16'h66);
    wr(A_CMD, 32'h4);
    wait_done();
    rd(A_RXD, r); check(r == 32'h66, "R2 released", r, 32'h66);

    // R2 synchronous mode off
    wr(A_CTRL, 32'h400);
    wr(A_TXD, 32'h77);
    repeat (40) @(negedge clk);
    rd(A_STAT, r); check(r[6] == 0, "R2 held while sync off", r[6], 0);
    push(16'h77);
    wr(A_CTRL, 32'h401);
    wait_done();
    rd(A_RXD, r); check(r == 32'h77, "R2 sync released", r, 32'h77);

    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R13 scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule